// File: doc/BRIEF.md
# Trace Circular Buffer Sink Controller

This block is the terminating sink of an on-chip trace path. It accepts trace words over a valid/ready input and stores them, one word at a time, into a fixed circular window of system memory. The hardware owns the write pointer. Software owns the read pointer and consumes data by writing a new absolute byte address to it. A small staging queue sits in front of the memory port. It drains when it fills, or when software issues a purge, so that words still in flight are pushed out before software reads them.

Occupancy is tracked with a sticky not-empty flag. If the two pointers are equal while that flag is set, the window is full. In that case the input stops accepting data until software moves the read pointer, and nothing already stored is overwritten. Software sees the state through a 32-bit register port. That port carries a capture enable, an interrupt configuration, a status word with a keyed clear, the two pointers and a purge command. A configurable interrupt tells software when the window goes from empty to holding data.

Top module: `tcb_sink`

## Requirements
- R1: After reset, capture is off, status (0x4C) reads 0, read address (0x5C) and write address (0x60) both read BASE_ADDR, interrupt config (0x08) reads 4 (level mode, active-high, disabled), and `irq` is low.
- R2: Bit 0 of the enable register (0x04) gates capture. While it is 0, `inReady` is low and no word is accepted.
- R3: Stored words land at consecutive word addresses, starting at the write pointer. The write-address register shows BASE_ADDR plus the byte offset. After the last word of the window, the pointer wraps to BASE_ADDR.
- R4: Accepted words wait in a staging queue of PEND_DEPTH words. They go to memory only when the queue is full, or after a write of 1 to bit 0 of the purge register (0x64). Bit 0 of that register reads 1 while draining and 0 once the queue is empty.
- R5: When the pointers are equal and status bit 0 is set, the window is full. Then status bit 1 reads 1, `inReady` is low and no memory write occurs. Status bit 2 is set if a word is offered while full. Moving the read pointer releases the full state.
- R6: Status bit 0 is 1 while unread data is held. A status write whose bits 3:0 equal 0xF clears bits 0 and 2 and any pending level interrupt. A status write with any other value has no effect.
- R7: A write to the read-address register is accepted only if it is word-aligned and lies in [BASE_ADDR, BASE_ADDR + window bytes). Any other write leaves the pointer unchanged.
- R8: Writing the current write address into the read-address register discards all pending data, and status bit 0 reads 0.
- R9: With interrupt config bit 0 set, an empty-to-not-empty transition raises the interrupt once. In pulse mode (bit 1 = 1) it lasts exactly one cycle. In level mode it holds until a status clear.
- R10: Interrupt config bit 2 selects polarity. At 1 the output is active-high. At 0 `irq` is the inverse of the internal request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Trace word offered |
| inReady | output | 1 | Trace word accepted this cycle when high with inValid |
| inData | input | DATA_W | Trace word |
| memWe | output | 1 | Memory write strobe |
| memAddr | output | 32 | Absolute byte address of the memory write |
| memData | output | DATA_W | Memory write data |
| regAddr | input | 8 | Register byte offset |
| regWe | input | 1 | Register write strobe |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for regAddr (combinational) |
| irq | output | 1 | Interrupt output |

## Verification
The embedded assertions check the cycle-level rules on every clock. The write pointer moves only when a word is written to memory, and the read pointer moves only on an accepted load. No memory write happens from an empty queue, and the queue count never exceeds its depth. A full window accepts nothing and stays full until software acts. A status clear or a discard really empties the window, and a pulse-mode interrupt never lasts two cycles. Only the bench's directed scenarios can show the end-to-end effects: which words reach which addresses across a wrap, the absence of overwrite after stalled offers, the address filtering of read-pointer writes, the keyed clear, the interrupt count per transition, and the polarity inversion.

// File: rtl/tcb_pkg.sv
package tcb_pkg;
  localparam int REG_W  = 32;
  localparam int REG_AW = 8;

  // register byte offsets
  localparam logic [REG_AW-1:0] OFS_ENABLE = 8'h04;
  localparam logic [REG_AW-1:0] OFS_IRQCFG = 8'h08;
  localparam logic [REG_AW-1:0] OFS_STATUS = 8'h4C;
  localparam logic [REG_AW-1:0] OFS_RDPTR  = 8'h5C;
  localparam logic [REG_AW-1:0] OFS_WRPTR  = 8'h60;
  localparam logic [REG_AW-1:0] OFS_PURGE  = 8'h64;

  localparam logic [3:0] CLEAR_KEY = 4'hF;

  // strobes from control to datapath
  typedef struct packed {
    logic push;
    logic pop;
    logic rdLoad;
  } dpStrobe_t;

  // interrupt configuration, bit 2..0
  typedef struct packed {
    logic activeHigh;
    logic pulseMode;
    logic enable;
  } irqCfg_t;
endpackage

// File: rtl/tcb_datapath.sv
module tcb_datapath
  import tcb_pkg::*;
#(
  parameter int          DATA_W     = 32,
  parameter logic [31:0] BASE_ADDR  = 32'h4000_0000,
  parameter int          BUF_WORDS  = 16,
  parameter int          PEND_DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  dpStrobe_t                  strb,
  input  logic [DATA_W-1:0]          inData,
  input  logic [REG_W-1:0]           regWdata,
  output logic                       memWe,
  output logic [31:0]                memAddr,
  output logic [DATA_W-1:0]          memData,
  output logic [$clog2(PEND_DEPTH+1)-1:0] pendCount,
  output logic                       ptrEq,
  output logic                       loadHitsWr,
  output logic                       rdAddrOk,
  output logic [31:0]                rdAddr,
  output logic [31:0]                wrAddr
);
  localparam int BYTES  = DATA_W / 8;
  localparam int BSH    = $clog2(BYTES);
  localparam int IDX_W  = (BUF_WORDS > 1) ? $clog2(BUF_WORDS) : 1;
  localparam int PIDX_W = (PEND_DEPTH > 1) ? $clog2(PEND_DEPTH) : 1;
  localparam int CNT_W  = $clog2(PEND_DEPTH + 1);
  localparam logic [32:0] SPAN = 33'(BUF_WORDS * BYTES);

  logic [IDX_W-1:0]  wrIdx, rdIdx, loadIdx;
  logic [PIDX_W-1:0] head, tail;
  logic [DATA_W-1:0] pendMem [PEND_DEPTH];
  logic [32:0]       relAddr;

  function automatic logic [IDX_W-1:0] nextW(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(BUF_WORDS - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [PIDX_W-1:0] nextP(input logic [PIDX_W-1:0] p);
    return (p == PIDX_W'(PEND_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // address filter for software read-pointer loads
  assign relAddr    = {1'b0, regWdata} - {1'b0, BASE_ADDR};
  assign rdAddrOk   = (relAddr < SPAN) && (regWdata[BSH-1:0] == '0);
  assign loadIdx    = relAddr[BSH +: IDX_W];
  assign loadHitsWr = (loadIdx == wrIdx);
  assign ptrEq      = (rdIdx == wrIdx);

  assign rdAddr  = BASE_ADDR + (32'(rdIdx) << BSH);
  assign wrAddr  = BASE_ADDR + (32'(wrIdx) << BSH);
  assign memWe   = strb.pop;
  assign memAddr = wrAddr;
  assign memData = pendMem[head];

  always_ff @(posedge clk) begin
    if (strb.push) pendMem[tail] <= inData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      head      <= '0;
      tail      <= '0;
      pendCount <= '0;
      wrIdx     <= '0;
      rdIdx     <= '0;
    end else begin
      if (strb.push) tail <= nextP(tail);
      if (strb.pop) begin
        head  <= nextP(head);
        wrIdx <= nextW(wrIdx);
      end
      if (strb.rdLoad) rdIdx <= loadIdx;
      case ({strb.push, strb.pop})
        2'b10:   pendCount <= pendCount + 1'b1;
        2'b01:   pendCount <= pendCount - 1'b1;
        default: pendCount <= pendCount;
      endcase
    end
  end

  // R3
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.pop |=> $stable(wrIdx));
  // R7
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rdLoad |=> $stable(rdIdx));
  // R4
  pop_has_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.pop |-> pendCount != '0);
  // R4
  pend_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    pendCount <= CNT_W'(PEND_DEPTH));
endmodule

// File: rtl/tcb_control.sv
module tcb_control
  import tcb_pkg::*;
#(
  parameter int PEND_DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       inValid,
  output logic                       inReady,
  input  logic [REG_AW-1:0]          regAddr,
  input  logic                       regWe,
  input  logic [3:0]                 ctlWdata,
  output logic [REG_W-1:0]           regRdata,
  output logic                       irq,
  output dpStrobe_t                  strb,
  input  logic [$clog2(PEND_DEPTH+1)-1:0] pendCount,
  input  logic                       ptrEq,
  input  logic                       loadHitsWr,
  input  logic                       rdAddrOk,
  input  logic [31:0]                rdAddr,
  input  logic [31:0]                wrAddr
);
  localparam int CNT_W = $clog2(PEND_DEPTH + 1);

  logic    capEn, notEmpty, stallSeen, drainAct, pulseQ, levelQ;
  irqCfg_t irqCfg;
  logic    enableWr, cfgWr, statusClr, purgeWr, bufFull, neRise, irqAct;

  assign enableWr  = regWe && (regAddr == OFS_ENABLE);
  assign cfgWr     = regWe && (regAddr == OFS_IRQCFG);
  assign statusClr = regWe && (regAddr == OFS_STATUS) && (ctlWdata == CLEAR_KEY);
  assign purgeWr   = regWe && (regAddr == OFS_PURGE) && ctlWdata[0];

  assign bufFull = ptrEq && notEmpty;
  assign inReady = capEn && !bufFull && (pendCount < CNT_W'(PEND_DEPTH));

  assign strb.push   = inValid && inReady;
  assign strb.pop    = drainAct && (pendCount != '0) && !bufFull;
  assign strb.rdLoad = regWe && (regAddr == OFS_RDPTR) && rdAddrOk;

  assign neRise = strb.pop && !notEmpty;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capEn     <= 1'b0;
      irqCfg    <= irqCfg_t'(3'b100);
      notEmpty  <= 1'b0;
      stallSeen <= 1'b0;
      drainAct  <= 1'b0;
      pulseQ    <= 1'b0;
      levelQ    <= 1'b0;
    end else begin
      if (enableWr) capEn <= ctlWdata[0];
      if (cfgWr)    irqCfg <= irqCfg_t'(ctlWdata[2:0]);

      if (strb.pop)                           notEmpty <= 1'b1;
      else if (statusClr)                     notEmpty <= 1'b0;
      else if (strb.rdLoad && loadHitsWr)     notEmpty <= 1'b0;

      if (inValid && capEn && bufFull)        stallSeen <= 1'b1;
      else if (statusClr)                     stallSeen <= 1'b0;

      if (purgeWr || pendCount == CNT_W'(PEND_DEPTH))
        drainAct <= 1'b1;
      else if (pendCount == '0 ||
               (pendCount == CNT_W'(1) && strb.pop && !strb.push))
        drainAct <= 1'b0;

      pulseQ <= neRise && irqCfg.enable && irqCfg.pulseMode;

      if (neRise && irqCfg.enable && !irqCfg.pulseMode) levelQ <= 1'b1;
      else if (!irqCfg.enable || irqCfg.pulseMode || statusClr) levelQ <= 1'b0;
    end
  end

  assign irqAct = irqCfg.pulseMode ? pulseQ : levelQ;
  assign irq    = irqCfg.activeHigh ? irqAct : !irqAct;

  always_comb begin
    case (regAddr)
      OFS_ENABLE: regRdata = {31'b0, capEn};
      OFS_IRQCFG: regRdata = {29'b0, irqCfg};
      OFS_STATUS: regRdata = {29'b0, stallSeen, bufFull, notEmpty};
      OFS_RDPTR:  regRdata = rdAddr;
      OFS_WRPTR:  regRdata = wrAddr;
      OFS_PURGE:  regRdata = {31'b0, drainAct};
      default:    regRdata = '0;
    endcase
  end

  // R5
  full_no_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    bufFull |-> !strb.push);
  // R5
  full_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    bufFull && !strb.rdLoad && !statusClr |=> bufFull);
  // R6
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rstN)
    statusClr && !strb.pop |=> !notEmpty);
  // R8
  discard_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdLoad && loadHitsWr && !strb.pop |=> !bufFull);
  // R9
  pulse_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    pulseQ |=> !pulseQ);
endmodule

// File: rtl/tcb_sink.sv
module tcb_sink
  import tcb_pkg::*;
#(
  parameter int          DATA_W     = 32,
  parameter logic [31:0] BASE_ADDR  = 32'h4000_0000,
  parameter int          BUF_WORDS  = 16,
  parameter int          PEND_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [DATA_W-1:0] inData,
  output logic              memWe,
  output logic [31:0]       memAddr,
  output logic [DATA_W-1:0] memData,
  input  logic [7:0]        regAddr,
  input  logic              regWe,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              irq
);
  localparam int CNT_W = $clog2(PEND_DEPTH + 1);

  dpStrobe_t        strb;
  logic [CNT_W-1:0] pendCount;
  logic             ptrEq, loadHitsWr, rdAddrOk;
  logic [31:0]      rdAddr, wrAddr;

  tcb_control #(.PEND_DEPTH(PEND_DEPTH)) uCtl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .regAddr(regAddr), .regWe(regWe), .ctlWdata(regWdata[3:0]),
    .regRdata(regRdata), .irq(irq), .strb(strb), .pendCount(pendCount),
    .ptrEq(ptrEq), .loadHitsWr(loadHitsWr), .rdAddrOk(rdAddrOk),
    .rdAddr(rdAddr), .wrAddr(wrAddr)
  );

  tcb_datapath #(
    .DATA_W(DATA_W), .BASE_ADDR(BASE_ADDR),
    .BUF_WORDS(BUF_WORDS), .PEND_DEPTH(PEND_DEPTH)
  ) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .inData(inData),
    .regWdata(regWdata), .memWe(memWe), .memAddr(memAddr),
    .memData(memData), .pendCount(pendCount), .ptrEq(ptrEq),
    .loadHitsWr(loadHitsWr), .rdAddrOk(rdAddrOk),
    .rdAddr(rdAddr), .wrAddr(wrAddr)
  );
endmodule

// File: tb/tb_tcb_sink.sv
module tb_tcb_sink;
  localparam logic [31:0] BASE = 32'h4000_0000;
  localparam int WORDS = 16;

  logic clk = 1'b0, rstN = 1'b0;
  logic inValid = 1'b0, inReady;
  logic [31:0] inData = '0;
  logic memWe;
  logic [31:0] memAddr, memData;
  logic [7:0] regAddr = '0;
  logic regWe = 1'b0;
  logic [31:0] regWdata = '0, regRdata;
  logic irq;

  int total = 0, bad = 0, irqHigh = 0;
  bit finished = 0;
  logic [31:0] mem [WORDS];
  logic [31:0] rv;

  always #2 clk = ~clk;

  tcb_sink #(.BASE_ADDR(BASE), .BUF_WORDS(WORDS), .PEND_DEPTH(4)) dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inData(inData), .memWe(memWe), .memAddr(memAddr), .memData(memData),
    .regAddr(regAddr), .regWe(regWe), .regWdata(regWdata),
    .regRdata(regRdata), .irq(irq)
  );

  always @(posedge clk) if (memWe) mem[int'((memAddr - BASE) >> 2)] <= memData;
  always @(posedge clk) if (irq) irqHigh++;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic regRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic pushWord(input logic [31:0] d);
    int guard = 0;
    @(negedge clk);
    while (!inReady && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    if (guard >= 200) check("R2 push timeout", 32'd0, 32'd1);
    inValid = 1'b1; inData = d;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic testReset();
    regRead(8'h4C, rv); check("R1 status", rv, 32'h0);
    regRead(8'h5C, rv); check("R1 rdaddr", rv, BASE);
    regRead(8'h60, rv); check("R1 wraddr", rv, BASE);
    regRead(8'h08, rv); check("R1 irqcfg", rv, 32'h4);
    regRead(8'h04, rv); check("R1 enable", rv, 32'h0);
    check("R2 ready while disabled", {31'b0, inReady}, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic testFillDrain();
    regWrite(8'h08, 32'h7);
    regWrite(8'h04, 32'h1);
    irqHigh = 0;
    check("R2 ready when enabled", {31'b0, inReady}, 32'h1);
    for (int i = 0; i < 4; i++) pushWord(32'hA000_0000 + i);
    waitCycles(12);
    regRead(8'h60, rv); check("R3 wraddr after 4", rv, BASE + 16);
    for (int i = 0; i < 4; i++) check("R3 mem word", mem[i], 32'hA000_0000 + i);
    regRead(8'h4C, rv); check("R6 status not empty", rv, 32'h1);
    check("R9 pulse count", irqHigh, 1);
  endtask

  task automatic testPurge();
    pushWord(32'hB000_0000);
    pushWord(32'hB000_0001);
    waitCycles(3);
    regRead(8'h60, rv); check("R4 held in staging", rv, BASE + 16);
    regWrite(8'h64, 32'h1);
    waitCycles(6);
    regRead(8'h60, rv); check("R4 wraddr after purge", rv, BASE + 24);
    check("R4 mem4", mem[4], 32'hB000_0000);
    check("R4 mem5", mem[5], 32'hB000_0001);
    regRead(8'h64, rv); check("R4 purge idle", rv, 32'h0);
    check("R9 no second pulse", irqHigh, 1);
  endtask

  task automatic testRdFilter();
    regWrite(8'h5C, BASE + 2);
    regRead(8'h5C, rv); check("R7 misaligned ignored", rv, BASE);
    regWrite(8'h5C, BASE + 64);
    regRead(8'h5C, rv); check("R7 above range ignored", rv, BASE);
    regWrite(8'h5C, BASE - 4);
    regRead(8'h5C, rv); check("R7 below range ignored", rv, BASE);
    regWrite(8'h5C, BASE + 8);
    regRead(8'h5C, rv); check("R7 valid load", rv, BASE + 8);
    regRead(8'h4C, rv); check("R7 status kept", rv, 32'h1);
  endtask

  task automatic testDiscard();
    regWrite(8'h5C, BASE + 24);
    regRead(8'h4C, rv); check("R8 discard empties", rv, 32'h0);
  endtask

  task automatic testLevelIrq();
    regWrite(8'h08, 32'h5);
    pushWord(32'hC000_0000);
    regWrite(8'h64, 32'h1);
    waitCycles(6);
    check("R9 level asserted", {31'b0, irq}, 32'h1);
    waitCycles(3);
    check("R9 level held", {31'b0, irq}, 32'h1);
    regWrite(8'h4C, 32'h7);
    regRead(8'h4C, rv); check("R6 wrong key ignored", rv, 32'h1);
    check("R6 irq kept on wrong key", {31'b0, irq}, 32'h1);
    regWrite(8'h4C, 32'hF);
    regRead(8'h4C, rv); check("R6 keyed clear", rv, 32'h0);
    check("R9 level cleared", {31'b0, irq}, 32'h0);
    regWrite(8'h08, 32'h1);
    regRead(8'h4C, rv);
    check("R10 active low idle", {31'b0, irq}, 32'h1);
    regWrite(8'h08, 32'h4);
    regRead(8'h4C, rv);
    check("R10 active high idle", {31'b0, irq}, 32'h0);
    regWrite(8'h5C, BASE + 28);
  endtask

  task automatic testFullWrap();
    for (int i = 0; i < 16; i++) pushWord(32'hD000_0000 + i);
    regWrite(8'h64, 32'h1);
    waitCycles(10);
    regRead(8'h60, rv); check("R3 wrap back", rv, BASE + 28);
    regRead(8'h4C, rv); check("R5 full status", rv, 32'h3);
    check("R5 ready low", {31'b0, inReady}, 32'h0);
    check("R3 first at idx7", mem[7], 32'hD000_0000);
    check("R3 wrapped to idx0", mem[0], 32'hD000_0009);
    check("R3 last at idx6", mem[6], 32'hD000_000F);
    @(negedge clk);
    inValid = 1'b1; inData = 32'hEEEE_EEEE;
    waitCycles(3);
    inValid = 1'b0;
    waitCycles(2);
    regRead(8'h4C, rv); check("R5 stall recorded", rv, 32'h7);
    check("R5 no overwrite", mem[7], 32'hD000_0000);
    regRead(8'h60, rv); check("R5 wr unchanged", rv, BASE + 28);
    regWrite(8'h5C, BASE + 44);
    regRead(8'h4C, rv); check("R5 released", rv, 32'h5);
    check("R5 ready back", {31'b0, inReady}, 32'h1);
    for (int i = 0; i < 4; i++) pushWord(32'hE000_0000 + i);
    waitCycles(10);
    check("R5 refill idx7", mem[7], 32'hE000_0000);
    check("R5 refill idx10", mem[10], 32'hE000_0003);
    regRead(8'h4C, rv); check("R5 full again", rv, 32'h7);
    regWrite(8'h4C, 32'hF);
    regRead(8'h4C, rv); check("R6 clear full", rv, 32'h0);
  endtask

  task automatic testDisable();
    regWrite(8'h04, 32'h0);
    regRead(8'h04, rv); check("R2 enable reads 0", rv, 32'h0);
    check("R2 ready low when disabled", {31'b0, inReady}, 32'h0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    waitCycles(3);
    rstN = 1'b1;
    waitCycles(2);
    testReset();
    testFillDrain();
    testPurge();
    testRdFilter();
    testDiscard();
    testLevelIrq();
    testFullWrap();
    testDisable();
    summary();
  end
endmodule